// File: doc/BRIEF.md
# Dual-Port Two-Word Burst SRAM

This block is a synthesizable model of a pipelined synchronous SRAM with a separate read port and write port. Both ports take commands on the rising edge of the input clock `k`. The complementary clock `k_n` runs 180 degrees away from it. The two ports work on their own, so one read and one write can be issued in the same cycle. Every access moves a two-word burst. One address selects one storage location. The low half of that location holds word A+0 and the high half holds word A+1.

A write captures its address, word A+0 and that word's byte enables on a `k` rise. Word A+1 and its byte enables are captured on the next `k_n` rise. The burst is committed to the array on the following `k` rise. A read captures its address on a `k` rise. On the next `k` rise the block drives word A+0 and raises the valid flag. On the `k_n` rise after that it drives word A+1. The output clocks are taken as tied to `k` and `k_n`.

If a read is issued in the same cycle as a write to the same address, or in the cycle after it, the read returns the new bytes. Those bytes are forwarded from the write path. Each port is controlled by a small state machine:
- **Write state machine:**
  - It moves from `WP_IDLE` to `WP_BURST` whenever the write select is sampled low.
  - It moves from either state back to `WP_IDLE` whenever the write select is sampled high.
  - `WP_BURST` means a captured burst commits at the next `k` rise.
- **Read state machine:**
  - It moves from `RP_IDLE` to `RP_DRIVE` one cycle after a read command.
  - It returns from `RP_DRIVE` to `RP_IDLE` on the first `k` rise with no fetch pending.
  - `RP_DRIVE` is the state in which burst data is on the output.

Top module: `burst2_sram`

## Requirements
- R1: While reset is asserted and after it, until the first read, `rdata` is 0 and `rvalid` is 0.
- R2: With `wr_sel_n` low at a `k` rise, the block captures `wr_addr` and `wdata` as word A+0 on that edge. It captures `wdata` as word A+1 on the next `k_n` rise. A later read of that address returns both words.
- R3: With `rd_sel_n` low at a `k` rise (edge t), `rvalid` is high from the `k` rise at t+1 until the `k` rise at t+2. `rdata` shows word A+0 from the `k` rise at t+1 and word A+1 from the `k_n` rise that follows it.
- R4: `wben_n` is active low and is sampled with each data word. Bit j covers bits [8j+7:8j] of that word. A high bit leaves that byte of that word unchanged in storage.
- R5: A read and a write issued in the same `k` cycle to different addresses are both carried out. The read returns the data stored before that write.
- R6: With a port select high at a `k` rise, that port does nothing. A deselected write leaves storage unchanged, and a deselected read leaves `rvalid` low.
- R7: A read issued in the same cycle as a write to the same address returns the new bytes, merged with the stored bytes under the write's byte enables. A read issued one cycle before that write returns the old data.
- R8: When no read is being output, `rvalid` is low and `rdata` holds the last value it drove, through both clock halves.
- R9: Reads issued in consecutive cycles produce gap-free bursts, with `rvalid` high throughout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| k | input | 1 | Input clock; commands and word A+0 are taken on its rise |
| k_n | input | 1 | Complementary clock; word A+1 is taken on its rise |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_sel_n | input | 1 | Active-low read port select |
| rd_addr | input | ADDR_W | Read burst address |
| wr_sel_n | input | 1 | Active-low write port select |
| wr_addr | input | ADDR_W | Write burst address |
| wdata | input | BYTES*BYTE_W | Write data, one word per clock half |
| wben_n | input | BYTES | Active-low byte write enables, one per byte of the current word |
| rdata | output | BYTES*BYTE_W | Read data, word A+0 after `k`, word A+1 after `k_n` |
| rvalid | output | 1 | High while a read burst is on `rdata` |

## Verification
The bench tries several patterns:
- **Single write then read:** shows the word order within a burst and the read latency.
- **Two overlapping writes with different byte masks on each word:** separates per-word masking from per-burst masking.
- **A read and a write in one cycle to different addresses:** shows that the ports are independent.
- **Read and write together on one address, with a read one cycle earlier:** tells forwarding apart from a stale array read, including a partial-mask merge.
- **Idle cycles after reads:** check the hold behaviour.
- **A run of back-to-back reads:** checks that the valid flag has no gap.

// File: rtl/b2s_pkg.sv
`timescale 1ns/1ps
package b2s_pkg;
    // Write port: a burst has been captured and commits at the next k rise.
    typedef enum logic {
        WP_IDLE  = 1'b0,
        WP_BURST = 1'b1
    } wp_state_t;

    // Read port: a fetched burst is being driven on the data output.
    typedef enum logic {
        RP_IDLE  = 1'b0,
        RP_DRIVE = 1'b1
    } rp_state_t;
endpackage

// File: rtl/b2s_array.sv
`timescale 1ns/1ps
module b2s_array #(
    parameter int ADDR_W = 4,
    parameter int BYTES  = 2,
    parameter int BYTE_W = 8
) (
    input  logic                        k,
    input  logic                        we,
    input  logic [ADDR_W-1:0]           waddr,
    input  logic [2*BYTES*BYTE_W-1:0]   wloc,
    input  logic [2*BYTES-1:0]          wben,
    input  logic [ADDR_W-1:0]           raddr,
    output logic [2*BYTES*BYTE_W-1:0]   rloc
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int LANES = 2 * BYTES;
    localparam int LW    = LANES * BYTE_W;

    logic [LW-1:0] mem [DEPTH];

    // Byte-lane write: lanes [BYTES-1:0] form word A+0, the rest word A+1.
    always_ff @(posedge k) begin
        if (we) begin
            for (int g = 0; g < LANES; g++) begin
                if (wben[g]) begin
                    mem[waddr][g*BYTE_W +: BYTE_W] <= wloc[g*BYTE_W +: BYTE_W];
                end
            end
        end
    end

    assign rloc = mem[raddr];
endmodule

// File: rtl/b2s_wr_port.sv
`timescale 1ns/1ps
module b2s_wr_port
    import b2s_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int BYTES  = 2,
    parameter int BYTE_W = 8
) (
    input  logic                        k,
    input  logic                        k_n,
    input  logic                        rst_n,
    input  logic                        wr_sel_n,
    input  logic [ADDR_W-1:0]           wr_addr,
    input  logic [BYTES*BYTE_W-1:0]     wdata,
    input  logic [BYTES-1:0]            wben_n,
    output logic                        cm_we,
    output logic [ADDR_W-1:0]           cm_addr,
    output logic [2*BYTES*BYTE_W-1:0]   cm_data,
    output logic [2*BYTES-1:0]          cm_ben
);
    localparam int W = BYTES * BYTE_W;

    wp_state_t         state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic [W-1:0]      d0_q, d1_q;
    logic [BYTES-1:0]  be0_q, be1_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WP_IDLE:  state_d = wr_sel_n ? WP_IDLE : WP_BURST;
            WP_BURST: state_d = wr_sel_n ? WP_IDLE : WP_BURST;
        endcase
    end

    always_ff @(posedge k or negedge rst_n) begin
        if (!rst_n) state_q <= WP_IDLE;
        else        state_q <= state_d;
    end

    // Word A+0, address and enables on the k rise of the command.
    always_ff @(posedge k or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            d0_q   <= '0;
            be0_q  <= '0;
        end else if (!wr_sel_n) begin
            addr_q <= wr_addr;
            d0_q   <= wdata;
            be0_q  <= ~wben_n;
        end
    end

    // Word A+1 on the following k_n rise; used only when a burst is open.
    always_ff @(posedge k_n or negedge rst_n) begin
        if (!rst_n) begin
            d1_q  <= '0;
            be1_q <= '0;
        end else begin
            d1_q  <= wdata;
            be1_q <= ~wben_n;
        end
    end

    always_comb begin
        cm_we   = (state_q == WP_BURST);
        cm_addr = addr_q;
        cm_data = {d1_q, d0_q};
        cm_ben  = {be1_q, be0_q};
    end

    // R2
    wr_open_chk: assert property (@(posedge k) disable iff (!rst_n)
        !wr_sel_n |=> (state_q == WP_BURST));

    // R6
    wr_desel_chk: assert property (@(posedge k) disable iff (!rst_n)
        wr_sel_n |=> !cm_we);
endmodule

// File: rtl/b2s_rd_port.sv
`timescale 1ns/1ps
module b2s_rd_port
    import b2s_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int BYTES  = 2,
    parameter int BYTE_W = 8
) (
    input  logic                        k,
    input  logic                        k_n,
    input  logic                        rst_n,
    input  logic                        rd_sel_n,
    input  logic [ADDR_W-1:0]           rd_addr,
    output logic [ADDR_W-1:0]           raddr,
    input  logic [2*BYTES*BYTE_W-1:0]   rloc,
    input  logic                        cm_we,
    input  logic [ADDR_W-1:0]           cm_addr,
    input  logic [2*BYTES*BYTE_W-1:0]   cm_data,
    input  logic [2*BYTES-1:0]          cm_ben,
    output logic [BYTES*BYTE_W-1:0]     rdata,
    output logic                        rvalid
);
    localparam int W     = BYTES * BYTE_W;
    localparam int LANES = 2 * BYTES;
    localparam int LW    = LANES * BYTE_W;

    rp_state_t         state_q, state_d;
    logic              pend_q;
    logic [ADDR_W-1:0] addr_q;
    logic [LW-1:0]     look;
    logic              hit;
    logic [W-1:0]      q0_q, q1_q, stage_q;
    logic              tog_k_q, tog_kn_q;

    always_ff @(posedge k or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            addr_q <= '0;
        end else begin
            pend_q <= !rd_sel_n;
            if (!rd_sel_n) addr_q <= rd_addr;
        end
    end

    assign raddr = addr_q;
    assign hit   = cm_we && (cm_addr == addr_q);

    // Forward bytes of a burst that commits on the same edge as the fetch.
    always_comb begin
        for (int g = 0; g < LANES; g++) begin
            look[g*BYTE_W +: BYTE_W] = (hit && cm_ben[g]) ?
                cm_data[g*BYTE_W +: BYTE_W] : rloc[g*BYTE_W +: BYTE_W];
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RP_IDLE:  state_d = pend_q ? RP_DRIVE : RP_IDLE;
            RP_DRIVE: state_d = pend_q ? RP_DRIVE : RP_IDLE;
        endcase
    end

    always_ff @(posedge k or negedge rst_n) begin
        if (!rst_n) state_q <= RP_IDLE;
        else        state_q <= state_d;
    end

    // k half: word A+0 of a fetch, otherwise repeat what is on the bus.
    always_ff @(posedge k or negedge rst_n) begin
        if (!rst_n) begin
            q0_q    <= '0;
            stage_q <= '0;
            tog_k_q <= 1'b0;
        end else begin
            tog_k_q <= !tog_k_q;
            if (pend_q) begin
                q0_q    <= look[W-1:0];
                stage_q <= look[LW-1:W];
            end else begin
                q0_q    <= q1_q;
            end
        end
    end

    // k_n half: word A+1 while driving, otherwise repeat what is on the bus.
    always_ff @(posedge k_n or negedge rst_n) begin
        if (!rst_n) begin
            q1_q     <= '0;
            tog_kn_q <= 1'b0;
        end else begin
            tog_kn_q <= !tog_kn_q;
            q1_q     <= (state_q == RP_DRIVE) ? stage_q : q0_q;
        end
    end

    // Toggle pair differs after a k rise and matches after a k_n rise.
    always_comb begin
        rvalid = (state_q == RP_DRIVE);
        rdata  = (tog_k_q ^ tog_kn_q) ? q0_q : q1_q;
    end

    // R3
    rd_launch_chk: assert property (@(posedge k) disable iff (!rst_n)
        !rd_sel_n |-> ##2 rvalid);

    // R6
    rd_desel_chk: assert property (@(posedge k) disable iff (!rst_n)
        rd_sel_n |-> ##2 !rvalid);

    // R7
    rd_fwd_chk: assert property (@(posedge k) disable iff (!rst_n)
        (pend_q && cm_we && (cm_addr == addr_q) && (&cm_ben))
        |=> (q0_q == $past(cm_data[W-1:0])));

    // R8
    rd_hold_chk: assert property (@(posedge k_n) disable iff (!rst_n)
        (state_q == RP_IDLE) |=> (q1_q == $past(q1_q)));
endmodule

// File: rtl/burst2_sram.sv
`timescale 1ns/1ps
module burst2_sram #(
    parameter int ADDR_W = 4,
    parameter int BYTES  = 2,
    parameter int BYTE_W = 8
) (
    input  logic                      k,
    input  logic                      k_n,
    input  logic                      rst_n,
    input  logic                      rd_sel_n,
    input  logic [ADDR_W-1:0]         rd_addr,
    input  logic                      wr_sel_n,
    input  logic [ADDR_W-1:0]         wr_addr,
    input  logic [BYTES*BYTE_W-1:0]   wdata,
    input  logic [BYTES-1:0]          wben_n,
    output logic [BYTES*BYTE_W-1:0]   rdata,
    output logic                      rvalid
);
    localparam int LW = 2 * BYTES * BYTE_W;

    logic              cm_we;
    logic [ADDR_W-1:0] cm_addr;
    logic [LW-1:0]     cm_data;
    logic [2*BYTES-1:0] cm_ben;
    logic [ADDR_W-1:0] raddr;
    logic [LW-1:0]     rloc;

    b2s_wr_port #(.ADDR_W(ADDR_W), .BYTES(BYTES), .BYTE_W(BYTE_W)) u_wr (
        .k(k), .k_n(k_n), .rst_n(rst_n),
        .wr_sel_n(wr_sel_n), .wr_addr(wr_addr), .wdata(wdata), .wben_n(wben_n),
        .cm_we(cm_we), .cm_addr(cm_addr), .cm_data(cm_data), .cm_ben(cm_ben)
    );

    b2s_array #(.ADDR_W(ADDR_W), .BYTES(BYTES), .BYTE_W(BYTE_W)) u_mem (
        .k(k), .we(cm_we), .waddr(cm_addr), .wloc(cm_data), .wben(cm_ben),
        .raddr(raddr), .rloc(rloc)
    );

    b2s_rd_port #(.ADDR_W(ADDR_W), .BYTES(BYTES), .BYTE_W(BYTE_W)) u_rd (
        .k(k), .k_n(k_n), .rst_n(rst_n),
        .rd_sel_n(rd_sel_n), .rd_addr(rd_addr),
        .raddr(raddr), .rloc(rloc),
        .cm_we(cm_we), .cm_addr(cm_addr), .cm_data(cm_data), .cm_ben(cm_ben),
        .rdata(rdata), .rvalid(rvalid)
    );
endmodule

// File: tb/sim_burst2_sram.sv
`timescale 1ns/1ps
module sim_burst2_sram;
    localparam int AW = 4;
    localparam int NB = 2;
    localparam int BW = 8;
    localparam int W  = NB * BW;

    logic          k = 1'b0;
    logic          k_n;
    logic          rst_n = 1'b0;
    logic          rd_sel_n = 1'b1;
    logic [AW-1:0] rd_addr = '0;
    logic          wr_sel_n = 1'b1;
    logic [AW-1:0] wr_addr = '0;
    logic [W-1:0]  wdata = '0;
    logic [NB-1:0] wben_n = '0;
    logic [W-1:0]  rdata;
    logic          rvalid;

    int checks = 0;
    int errors = 0;
    logic done = 1'b0;

    logic [W-1:0] obs0, obs1;
    logic         obsv0, obsv1;

    always #4 k = ~k;
    assign k_n = ~k;

    burst2_sram #(.ADDR_W(AW), .BYTES(NB), .BYTE_W(BW)) u0 (
        .k(k), .k_n(k_n), .rst_n(rst_n),
        .rd_sel_n(rd_sel_n), .rd_addr(rd_addr),
        .wr_sel_n(wr_sel_n), .wr_addr(wr_addr),
        .wdata(wdata), .wben_n(wben_n),
        .rdata(rdata), .rvalid(rvalid)
    );

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One k cycle: command and word A+0 before k rise, word A+1 before k_n rise.
    task automatic cyc(input logic rs, input logic [AW-1:0] ra,
                       input logic ws, input logic [AW-1:0] wa,
                       input logic [W-1:0] w0, input logic [NB-1:0] m0,
                       input logic [W-1:0] w1, input logic [NB-1:0] m1);
        rd_sel_n = rs; rd_addr = ra; wr_sel_n = ws; wr_addr = wa;
        wdata = w0; wben_n = m0;
        @(posedge k); #2;
        obs0 = rdata; obsv0 = rvalid;
        wdata = w1; wben_n = m1;
        @(posedge k_n); #2;
        obs1 = rdata; obsv1 = rvalid;
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [W-1:0] w0, input logic [W-1:0] w1,
                      input logic [NB-1:0] m0, input logic [NB-1:0] m1);
        cyc(1'b1, '0, 1'b0, a, w0, m0, w1, m1);
    endtask

    task automatic rd(input logic [AW-1:0] a);
        cyc(1'b0, a, 1'b1, '0, '0, '0, '0, '0);
    endtask

    task automatic idle();
        cyc(1'b1, '0, 1'b1, '0, '0, '0, '0, '0);
    endtask

    task automatic expect_burst(input string tag, input logic [W-1:0] e0, input logic [W-1:0] e1);
        check({tag, " word0"}, obs0, e0);
        check({tag, " word1"}, obs1, e1);
        check({tag, " valid0"}, {15'd0, obsv0}, 16'd1);
        check({tag, " valid1"}, {15'd0, obsv1}, 16'd1);
    endtask

    task automatic t_reset();
        #3;
        check("R1 rdata in reset", rdata, 16'h0000);
        check("R1 rvalid in reset", {15'd0, rvalid}, 16'd0);
        repeat (3) @(posedge k);
        @(posedge k_n); #1 rst_n = 1'b1; #1;
        idle();
        check("R1 rdata after reset", obs1, 16'h0000);
        check("R1 rvalid after reset", {15'd0, obsv1}, 16'd0);
    endtask

    task automatic t_basic();
        wr(4'd3, 16'h1111, 16'h2222, 2'b00, 2'b00);
        rd(4'd3);
        check("R3 no valid on command cycle", {15'd0, obsv0}, 16'd0);
        idle();
        expect_burst("R2 R3 basic", 16'h1111, 16'h2222);
    endtask

    task automatic t_hold();
        idle();
        check("R8 hold k half", obs0, 16'h2222);
        check("R8 hold k_n half", obs1, 16'h2222);
        check("R8 valid low k half", {15'd0, obsv0}, 16'd0);
        check("R8 valid low k_n half", {15'd0, obsv1}, 16'd0);
    endtask

    task automatic t_mask();
        wr(4'd5, 16'hA1B2, 16'hC3D4, 2'b00, 2'b00);
        wr(4'd5, 16'hFFFF, 16'hEEEE, 2'b10, 2'b01);
        rd(4'd5);
        idle();
        expect_burst("R4 byte mask", 16'hA1FF, 16'hEED4);
    endtask

    task automatic t_deselect();
        cyc(1'b1, 4'd5, 1'b1, 4'd5, 16'h0000, 2'b00, 16'h0000, 2'b00);
        check("R6 deselected read no valid", {15'd0, obsv1}, 16'd0);
        rd(4'd5);
        idle();
        expect_burst("R6 deselected write", 16'hA1FF, 16'hEED4);
        idle();
        check("R6 deselected read keeps valid low", {15'd0, obsv0}, 16'd0);
    endtask

    task automatic t_concurrent();
        cyc(1'b0, 4'd3, 1'b0, 4'd7, 16'h7070, 2'b00, 16'h7171, 2'b00);
        rd(4'd7);
        expect_burst("R5 concurrent read", 16'h1111, 16'h2222);
        idle();
        expect_burst("R5 concurrent write", 16'h7070, 16'h7171);
    endtask

    task automatic t_forward();
        wr(4'd9, 16'h0101, 16'h0202, 2'b00, 2'b00);
        rd(4'd9);
        cyc(1'b0, 4'd9, 1'b0, 4'd9, 16'h9A9A, 2'b00, 16'h9B9B, 2'b00);
        expect_burst("R7 read before write old", 16'h0101, 16'h0202);
        cyc(1'b0, 4'd9, 1'b0, 4'd9, 16'h1234, 2'b10, 16'h5678, 2'b00);
        expect_burst("R7 same cycle forward", 16'h9A9A, 16'h9B9B);
        idle();
        expect_burst("R7 R4 partial forward", 16'h9A34, 16'h5678);
    endtask

    task automatic t_stream();
        rd(4'd3);
        rd(4'd7);
        expect_burst("R9 stream 1", 16'h1111, 16'h2222);
        rd(4'd9);
        expect_burst("R9 stream 2", 16'h7070, 16'h7171);
        idle();
        expect_burst("R9 stream 3", 16'h9A34, 16'h5678);
    endtask

    initial begin
        t_reset();
        t_basic();
        t_hold();
        t_mask();
        t_deselect();
        t_concurrent();
        t_forward();
        t_stream();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R3 watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule